// File: doc/BRIEF.md
# Paged management register bridge

This block lets a local host read and write 32-bit switch registers that are reachable only through a management bus with 16-bit transfers and a small address space. The host gives a byte address, a direction flag and, for writes, 32 bits of data. The bridge turns that request into three bus transactions in a fixed order. The first is a write that selects a register page. The bridge then waits a fixed number of quiet cycles so the page change can take effect. Last come two 16-bit data transfers that cover the two halves of the word.

The byte address is cut into three fields. A 9-bit page number goes out in the page-select write. A 3-bit sub-address sets the low bits of the PHY address used for the data transfers. An even register index picks the register that holds the lower half; the upper half sits at that index plus one. The bridge handles one request at a time. Each bus transaction is held on the bus until the responder acknowledges it.

Top module: `paged_mdio_bridge`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `req_ready` is 1 and both `mb_req` and `rsp_done` are 0.
- R2: After a request is accepted (`req_valid` and `req_ready` high on the same edge), `req_ready` stays 0 up to and including the `rsp_done` cycle. Requests offered during that time are not taken. `req_ready` is 1 again on the cycle after `rsp_done`.
- R3: Every access opens with a bus write to PHY address 0x18, register 0. Its 16-bit data is the page number `req_addr[17:9]` with zeros above it. This transaction is on the bus on the cycle right after acceptance.
- R4: After the page write is acknowledged, `mb_req` stays 0 for exactly `SETTLE_CYCLES` cycles. The first data transaction is then issued.
- R5: Both data transactions use PHY address 0x10 OR `req_addr[8:6]`. The lower-half register index is `req_addr[5:2]` times two. The upper-half index is that value plus one.
- R6: A read fetches the lower-half register first and the upper-half register second. `rsp_rdata` is {upper data, lower data}: the upper half in bits 31:16 and the lower half in bits 15:0.
- R7: A write sends `req_wdata[31:16]` to the upper-half register first, then `req_wdata[15:0]` to the lower-half register.
- R8: While `mb_req` is 1 and `mb_ack` is 0, the transaction fields stay stable and the request stays up. Read data is taken from `mb_rdata` on the acknowledge cycle.
- R9: `rsp_done` is a one-cycle pulse on the cycle after the last data transaction is acknowledged. During that pulse `rsp_rdata` holds the read result.
- R10: Address bits 1:0 and 31:18 have no effect on any bus transaction or on the read result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request offered |
| req_ready | output | 1 | Bridge idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Register byte address |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid while `rsp_done` is high |
| rsp_done | output | 1 | One-cycle completion pulse |
| mb_req | output | 1 | Bus transaction pending |
| mb_ack | input | 1 | Bus transaction completed (one-cycle pulse) |
| mb_write | output | 1 | Bus transaction direction, 1 = write |
| mb_phy | output | 5 | PHY address of the transaction |
| mb_reg | output | 5 | Register number of the transaction |
| mb_wdata | output | 16 | Write data of the transaction |
| mb_rdata | input | 16 | Read data returned with `mb_ack` |

## Verification
The page-select request must show up on the cycle after acceptance. The quiet gap after its acknowledge must last exactly `SETTLE_CYCLES` cycles. `rsp_done` must arrive one cycle after the second data acknowledge, and `req_ready` must return one cycle later. The bench's responder model acknowledges with a latency that changes from access to access. It counts the quiet cycles and logs every transaction, so order, fields and gap are compared against values the bench works out from the address. Host-side outputs are sampled on the falling edge, half a cycle after the edge that changes them. The bench checks `rsp_done` and `rsp_rdata` on the falling edge where the pulse is first seen, and checks `req_ready` on the falling edge after that.

// File: rtl/pmb_pkg.sv
package pmb_pkg;

    localparam int WORD_W  = 32;
    localparam int HALF_W  = 16;
    localparam int PHY_W   = 5;
    localparam int REG_W   = 5;
    localparam int SUB_W   = 3;
    localparam int PAGE_W  = 9;

    localparam logic [PHY_W-1:0] PAGE_SEL_PHY  = 5'h18;
    localparam logic [REG_W-1:0] PAGE_SEL_REG  = '0;
    localparam logic [PHY_W-1:0] DATA_PHY_BASE = 5'h10;
    localparam logic [REG_W-1:0] REG_PAIR_MASK = 5'h1E;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [SUB_W-1:0]  sub;
        logic [REG_W-1:0]  reg_lo;
    } addr_fields_t;

    typedef struct packed {
        logic              write;
        logic [PHY_W-1:0]  phy;
        logic [REG_W-1:0]  regn;
        logic [HALF_W-1:0] data;
    } mb_txn_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PAGE,
        ST_SETTLE,
        ST_FIRST,
        ST_SECOND,
        ST_DONE
    } seq_state_t;

    // Halve the byte address, then cut out register pair, sub-address and page.
    function automatic addr_fields_t split_byte_addr(input logic [WORD_W-1:0] baddr);
        logic [WORD_W-1:0] half_addr;
        addr_fields_t      f;
        half_addr = baddr >> 1;
        f.reg_lo  = half_addr[REG_W-1:0] & REG_PAIR_MASK;
        f.sub     = half_addr[REG_W+SUB_W-1:REG_W];
        f.page    = half_addr[REG_W+SUB_W+PAGE_W-1:REG_W+SUB_W];
        return f;
    endfunction

endpackage

// File: rtl/pmb_addr_split.sv
module pmb_addr_split
    import pmb_pkg::*;
(
    input  logic [WORD_W-1:0] byte_addr,
    output addr_fields_t      fields
);

    assign fields = split_byte_addr(byte_addr);

endmodule

// File: rtl/pmb_settle_timer.sv
module pmb_settle_timer #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic expired
);

    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CNT_W'(CYCLES);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy    = (cnt != '0);
    assign expired = (cnt == CNT_W'(1));

    // R4: the expiry flag lasts one cycle and the timer then goes quiet
    p_expire_once_r4: assert property (@(posedge clk) disable iff (rst)
        (expired && !start) |=> (!expired && !busy));

    initial begin
        assert (CYCLES >= 1) else $error("settle interval must be at least one cycle");
    end

endmodule

// File: rtl/pmb_txn_select.sv
module pmb_txn_select
    import pmb_pkg::*;
(
    input  seq_state_t        state,
    input  logic              is_write,
    input  addr_fields_t      fields,
    input  logic [WORD_W-1:0] wdata,
    output mb_txn_t           txn,
    output logic              active
);

    logic [PHY_W-1:0] data_phy;
    logic [REG_W-1:0] reg_hi;

    assign data_phy = DATA_PHY_BASE | PHY_W'(fields.sub);
    assign reg_hi   = fields.reg_lo | REG_W'(1);

    always_comb begin
        txn    = '0;
        active = 1'b0;
        unique case (state)
            ST_PAGE: begin
                active     = 1'b1;
                txn.write  = 1'b1;
                txn.phy    = PAGE_SEL_PHY;
                txn.regn   = PAGE_SEL_REG;
                txn.data   = HALF_W'(fields.page);
            end
            ST_FIRST: begin
                active     = 1'b1;
                txn.write  = is_write;
                txn.phy    = data_phy;
                txn.regn   = is_write ? reg_hi : fields.reg_lo;
                txn.data   = is_write ? wdata[WORD_W-1:HALF_W] : '0;
            end
            ST_SECOND: begin
                active     = 1'b1;
                txn.write  = is_write;
                txn.phy    = data_phy;
                txn.regn   = is_write ? fields.reg_lo : reg_hi;
                txn.data   = is_write ? wdata[HALF_W-1:0] : '0;
            end
            default: begin
                active = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/paged_mdio_bridge.sv
module paged_mdio_bridge
    import pmb_pkg::*;
#(
    parameter int SETTLE_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [WORD_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic              rsp_done,
    output logic              mb_req,
    input  logic              mb_ack,
    output logic              mb_write,
    output logic [PHY_W-1:0]  mb_phy,
    output logic [REG_W-1:0]  mb_reg,
    output logic [HALF_W-1:0] mb_wdata,
    input  logic [HALF_W-1:0] mb_rdata
);

    seq_state_t        st;
    logic              is_wr;
    addr_fields_t      fld_d;
    addr_fields_t      fld_q;
    logic [WORD_W-1:0] wdata_q;
    logic [HALF_W-1:0] rd_lo_q;
    logic [HALF_W-1:0] rd_hi_q;
    logic              tmr_start;
    logic              tmr_busy;
    logic              tmr_expired;
    mb_txn_t           txn;
    logic              txn_active;

    pmb_addr_split u_split (
        .byte_addr (req_addr),
        .fields    (fld_d)
    );

    assign tmr_start = (st == ST_PAGE) && mb_ack;

    pmb_settle_timer #(.CYCLES(SETTLE_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start   (tmr_start),
        .busy    (tmr_busy),
        .expired (tmr_expired)
    );

    pmb_txn_select u_select (
        .state    (st),
        .is_write (is_wr),
        .fields   (fld_q),
        .wdata    (wdata_q),
        .txn      (txn),
        .active   (txn_active)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            is_wr   <= 1'b0;
            fld_q   <= '0;
            wdata_q <= '0;
            rd_lo_q <= '0;
            rd_hi_q <= '0;
        end else begin
            unique case (st)
                ST_IDLE: if (req_valid) begin
                    is_wr   <= req_write;
                    fld_q   <= fld_d;
                    wdata_q <= req_wdata;
                    st      <= ST_PAGE;
                end
                ST_PAGE: if (mb_ack) st <= ST_SETTLE;
                ST_SETTLE: if (tmr_expired) st <= ST_FIRST;
                ST_FIRST: if (mb_ack) begin
                    if (!is_wr) rd_lo_q <= mb_rdata;
                    st <= ST_SECOND;
                end
                ST_SECOND: if (mb_ack) begin
                    if (!is_wr) rd_hi_q <= mb_rdata;
                    st <= ST_DONE;
                end
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (st == ST_IDLE);
    assign rsp_done  = (st == ST_DONE);
    assign rsp_rdata = {rd_hi_q, rd_lo_q};
    assign mb_req    = txn_active;
    assign mb_write  = txn.write;
    assign mb_phy    = txn.phy;
    assign mb_reg    = txn.regn;
    assign mb_wdata  = txn.data;

    // R2: no second request is taken right after an acceptance
    p_ready_drop_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R3: the page-select write follows acceptance at once
    p_page_first_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=>
            (mb_req && mb_write && mb_phy == PAGE_SEL_PHY && mb_reg == PAGE_SEL_REG));

    // R4: the bus stays quiet while the settle timer runs
    p_quiet_settle_r4: assert property (@(posedge clk) disable iff (rst)
        tmr_busy |-> !mb_req);

    // R5: non-page transactions go to the data PHY group
    p_data_phy_r5: assert property (@(posedge clk) disable iff (rst)
        (mb_req && mb_phy != PAGE_SEL_PHY) |->
            (mb_phy[PHY_W-1:SUB_W] == DATA_PHY_BASE[PHY_W-1:SUB_W]));

    // R8: an unacknowledged transaction is held unchanged
    p_hold_txn_r8: assert property (@(posedge clk) disable iff (rst)
        (mb_req && !mb_ack) |=>
            (mb_req && $stable(mb_write) && $stable(mb_phy) &&
             $stable(mb_reg) && $stable(mb_wdata)));

    // R9: completion is a single-cycle pulse followed by readiness
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> (!rsp_done && req_ready));

endmodule

// File: tb/tb_paged_mdio_bridge.sv
module tb_paged_mdio_bridge;

    localparam int SETTLE = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic        rsp_done;
    logic        mb_req;
    logic        mb_ack = 1'b0;
    logic        mb_write;
    logic [4:0]  mb_phy;
    logic [4:0]  mb_reg;
    logic [15:0] mb_wdata;
    logic [15:0] mb_rdata = '0;

    paged_mdio_bridge #(.SETTLE_CYCLES(SETTLE)) dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
        .mb_req(mb_req), .mb_ack(mb_ack), .mb_write(mb_write),
        .mb_phy(mb_phy), .mb_reg(mb_reg), .mb_wdata(mb_wdata), .mb_rdata(mb_rdata)
    );

    always #4 clk = ~clk;

    int errors = 0;
    int checks = 0;

    // Responder state and transaction log
    int          rsp_lat = 0;
    int          wait_cnt = 0;
    int          idle_run = 0;
    int          log_n = 0;
    logic [8:0]  cur_page = '0;
    logic        log_wr   [4];
    logic [4:0]  log_phy  [4];
    logic [4:0]  log_reg  [4];
    logic [15:0] log_data [4];
    int          log_gap  [4];

    function automatic logic [15:0] model_value(int pg, int phy, int rg);
        int v;
        v = (pg * 97) ^ (phy * 331) ^ (rg * 29) ^ 'h5A3C;
        return v[15:0];
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Bus responder: acknowledges after rsp_lat waiting edges, logs each transaction
    initial begin
        forever begin
            @(posedge clk);
            if (rst) begin
                mb_ack   <= 1'b0;
                wait_cnt = 0;
                idle_run = 0;
            end else if (mb_ack) begin
                mb_ack <= 1'b0;
            end else if (mb_req) begin
                if (wait_cnt < rsp_lat) begin
                    wait_cnt++;
                end else begin
                    wait_cnt = 0;
                    mb_ack <= 1'b1;
                    if (!mb_write) mb_rdata <= model_value(int'(cur_page), int'(mb_phy), int'(mb_reg));
                    if (log_n < 4) begin
                        log_wr[log_n]   = mb_write;
                        log_phy[log_n]  = mb_phy;
                        log_reg[log_n]  = mb_reg;
                        log_data[log_n] = mb_wdata;
                        log_gap[log_n]  = idle_run;
                    end
                    log_n++;
                    idle_run = 0;
                    if (mb_write && mb_phy == 5'h18 && mb_reg == 5'h0) cur_page = mb_wdata[8:0];
                end
            end else begin
                idle_run++;
            end
        end
    end

    task automatic do_access(input bit wr, input logic [31:0] addr, input logic [31:0] wd,
                             input int lat, input bit nag);
        int pg, sub, lo, hi, dphy, n;
        logic [31:0] exp_rd;
        pg   = int'(addr[17:9]);
        sub  = int'(addr[8:6]);
        lo   = int'(addr[5:2]) * 2;
        hi   = lo + 1;
        dphy = 'h10 | sub;
        @(negedge clk);
        log_n     = 0;
        rsp_lat   = lat;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = addr;
        req_wdata = wd;
        chk(req_ready == 1'b1, "R2 idle ready", req_ready, 1);
        @(negedge clk);
        chk(req_ready == 1'b0, "R2 ready low after accept", req_ready, 0);
        if (nag) begin
            // keep offering a different request while busy; it must not be taken
            req_addr  = addr ^ 32'h0001_FFC0;
            req_write = ~wr;
            @(negedge clk);
            chk(req_ready == 1'b0, "R2 busy ignores request", req_ready, 0);
            @(negedge clk);
        end
        req_valid = 1'b0;
        n = 0;
        while (!rsp_done && n < 300) begin
            @(negedge clk);
            n++;
            if (!rsp_done) chk(req_ready == 1'b0, "R2 ready low while busy", req_ready, 0);
        end
        chk(rsp_done == 1'b1, "R9 done seen", rsp_done, 1);
        chk(log_n == 3, "R9 done after three transactions", log_n, 3);
        if (!wr) begin
            exp_rd = {model_value(pg, dphy, hi), model_value(pg, dphy, lo)};
            chk(rsp_rdata == exp_rd, "R6 R10 read data", rsp_rdata, exp_rd);
        end
        // R3: page-select write
        chk(log_wr[0] == 1'b1 && log_phy[0] == 5'h18 && log_reg[0] == 5'h0,
            "R3 page select target", {log_wr[0], log_phy[0], log_reg[0]}, {1'b1, 5'h18, 5'h0});
        chk(log_data[0] == 16'(pg), "R3 R10 page value", log_data[0], pg);
        chk(log_gap[1] == SETTLE, "R4 settle gap", log_gap[1], SETTLE);
        chk(log_phy[1] == 5'(dphy) && log_phy[2] == 5'(dphy), "R5 data phy",
            {log_phy[1], log_phy[2]}, {5'(dphy), 5'(dphy)});
        if (wr) begin
            chk(log_wr[1] && log_wr[2], "R7 write direction", {log_wr[1], log_wr[2]}, 2'b11);
            chk(log_reg[1] == 5'(hi) && log_reg[2] == 5'(lo), "R5 R7 write order",
                {log_reg[1], log_reg[2]}, {5'(hi), 5'(lo)});
            chk(log_data[1] == wd[31:16] && log_data[2] == wd[15:0], "R7 write halves",
                {log_data[1], log_data[2]}, wd);
        end else begin
            chk(!log_wr[1] && !log_wr[2], "R6 read direction", {log_wr[1], log_wr[2]}, 2'b00);
            chk(log_reg[1] == 5'(lo) && log_reg[2] == 5'(hi), "R5 R6 read order",
                {log_reg[1], log_reg[2]}, {5'(lo), 5'(hi)});
        end
        @(negedge clk);
        chk(rsp_done == 1'b0, "R9 done single pulse", rsp_done, 0);
        chk(req_ready == 1'b1, "R2 ready after done", req_ready, 1);
        chk(log_n == 3, "R2 no extra access", log_n, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1 && mb_req == 1'b0 && rsp_done == 1'b0, "R1 reset state",
            {req_ready, mb_req, rsp_done}, 3'b100);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1 && mb_req == 1'b0 && rsp_done == 1'b0, "R1 after release",
            {req_ready, mb_req, rsp_done}, 3'b100);
        for (int sub = 0; sub < 8; sub++) begin
            for (int idx = 0; idx < 16; idx++) begin
                for (int wr = 0; wr < 2; wr++) begin
                    int          k;
                    int          pg;
                    logic [31:0] a;
                    logic [31:0] d;
                    k  = sub * 32 + idx * 2 + wr;
                    pg = (k * 13 + 5) % 512;
                    a  = (32'(k * 'h2F3) << 18) | (32'(pg) << 9) | (32'(sub) << 6)
                         | (32'(idx) << 2) | 32'(k % 4);
                    d  = 32'(k * 'h9E37_79B1 + 'h1357);
                    do_access(wr[0], a, d, k % 3, (k % 5) == 0);
                end
            end
        end
        // R10: same register read with different ignored address bits gives same result
        begin
            logic [31:0] r0;
            do_access(1'b0, 32'h0001_2345 & 32'h0003_FFFC, 32'h0, 0, 1'b0);
            r0 = rsp_rdata;
            do_access(1'b0, (32'h0001_2345 & 32'h0003_FFFC) | 32'hFFFC_0003, 32'h0, 2, 1'b0);
            chk(rsp_rdata == r0, "R10 ignored bits", rsp_rdata, r0);
        end
        // R4 with the longest responder latency and back-to-back accesses
        do_access(1'b1, 32'h0003_FFFC, 32'hDEAD_BEEF, 4, 1'b1);
        do_access(1'b0, 32'h0000_0000, 32'h0, 4, 1'b0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule